// File: doc/BRIEF.md
# Balanced Direct-Mapped Cache with Programmable Row Decoding

This block is a level-one cache controller that keeps the one-lookup timing of a direct-mapped cache while letting a heavily used index spread its blocks over several lines. The set index is split in two. A fixed-decoded field picks a group of eight lines. A second field is compared against a small rewritable match entry kept beside each line of that group. At most one line can match, so a hit still enables exactly one line and its data is returned without a way multiplexer after the read.

On a miss the controller picks a line in the addressed group. It prefers the line whose match entry already holds the same programmable value, then an empty line, then the replacement policy's choice. A dirty victim is written back to the next level. The line is then refilled, and the new match entry and tag are written together with the line. The replacement policy is a build parameter: least-recently-used order per group, or a free-running pseudo-random generator.

The CPU holds a request stable until `cpu_hit` is seen. The memory side moves whole lines under a request/acknowledge handshake.

Top module: `bcache_top`

## Requirements
- R1: Address fields, from bit 0 upward: byte offset in bits 4:0 (word select in bits 4:2), fixed group index in bits 10:5, programmable index in bits 16:11, tag in bits 31:17. A written-back line goes out at the address rebuilt from its stored tag, stored programmable index and group, with the offset bits zero.
- R2: A read that hits asserts `cpu_hit` for one cycle on the cycle after the request is sampled, returns the addressed word on `cpu_rdata`, and starts no memory transfer.
- R3: A miss keeps `cpu_hit` low and issues one refill read at the line-aligned request address (offset bits zero). `cpu_hit` is asserted with the requested word on the cycle after the refill is acknowledged.
- R4: A write stores `cpu_wdata` into the addressed word and marks the line dirty. Any later read of that word returns the last value written, whether the line has stayed resident or not.
- R5: A dirty victim is written back, with its full line contents, before the refill read starts. A clean victim is not written back. Line data carries word i in bits 32*i+31:32*i on both memory data buses.
- R6: Up to eight blocks that share a group but differ in programmable index are resident together, and each of them then hits.
- R7: A miss whose programmable index matches a valid entry of the group replaces that same line. No two valid entries of a group ever hold the same programmable index, and the other lines of the group stay resident.
- R8: While a group still has an empty line, a miss fills an empty line and evicts nothing.
- R9: With LRU replacement and a full group, the victim is the line touched least recently, where both hits and fills count as touches.
- R10: After reset every entry is invalid and no line is dirty: `cpu_hit` and `mem_req` are low, and the first access misses.
- R11: `mem_req`, `mem_we` and `mem_addr` stay asserted and stable until `mem_ack` is seen. A write-back acknowledge is followed directly by the refill read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_hit` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_hit | output | 1 | One-cycle completion of the access |
| cpu_rdata | output | 32 | Read word, valid with `cpu_hit` |
| mem_req | output | 1 | Next-level transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Line-aligned transfer address |
| mem_wdata | output | 256 | Write-back line |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 256 | Refill line, valid with `mem_ack` |

## Verification
The bench starts with directed sequences. Eight programmable values are loaded into one group, which a plain direct-mapped cache could not hold at once, and the bench checks that each of them hits. The group is then reordered by hits so that the next fill must evict one known line. Two blocks that share a programmable value but differ in tag separate the forced-victim rule from the LRU choice. After that, seeded random reads and writes are confined to three groups, twelve programmable values and two tags. This keeps evictions, write-backs and conflicts on the match entries frequent. Each access is compared against a block-level LRU model for hit or miss, write-back count and address, and against a shadow memory for read data and write-back contents.

// File: rtl/bcache_pkg.sv
package bcache_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_RF} st_e;
    typedef enum logic {REPL_RANDOM, REPL_LRU} repl_e;
endpackage

// File: rtl/bcache_decoder.sv
module bcache_decoder #(
    parameter int WAYS  = 8,
    parameter int WAY_W = 3,
    parameter int PI_W  = 6,
    parameter int TAG_W = 15
) (
    input  logic [WAYS-1:0]             ent_valid,
    input  logic [WAYS-1:0][PI_W-1:0]   ent_pd,
    input  logic [WAYS-1:0][TAG_W-1:0]  ent_tag,
    input  logic [PI_W-1:0]             req_pd,
    input  logic [TAG_W-1:0]            req_tag,
    output logic [WAYS-1:0]             pd_match,
    output logic                        match_any,
    output logic [WAY_W-1:0]            match_way,
    output logic                        tag_hit,
    output logic                        free_any,
    output logic [WAY_W-1:0]            free_way
);
    // one comparator per line of the group: the programmable row decode
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign pd_match[w] = ent_valid[w] && (ent_pd[w] == req_pd);
    end

    always_comb begin
        match_any = |pd_match;
        match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (pd_match[w]) match_way = WAY_W'(w);
        end
        tag_hit  = match_any && (ent_tag[match_way] == req_tag);
        free_any = ~&ent_valid;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!ent_valid[w]) free_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/bcache_repl.sv
module bcache_repl #(
    parameter bcache_pkg::repl_e REPL = bcache_pkg::REPL_LRU,
    parameter int NPI_W  = 6,
    parameter int WAY_W  = 3,
    localparam int WAYS   = 1 << WAY_W,
    localparam int GROUPS = 1 << NPI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPI_W-1:0] grp,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim_way
);
    if (REPL == bcache_pkg::REPL_LRU) begin : g_lru
        // age 0 = most recent, WAYS-1 = least recent; ages form a permutation
        logic [WAYS-1:0][WAY_W-1:0] age_q [GROUPS];
        logic [WAYS-1:0][WAY_W-1:0] row_cur, row_d;

        always_comb begin
            row_cur    = age_q[grp];
            victim_way = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (w == int'(touch_way))             row_d[w] = '0;
                else if (row_cur[w] < row_cur[touch_way]) row_d[w] = row_cur[w] + 1'b1;
                else                                  row_d[w] = row_cur[w];
                if (row_cur[w] == WAY_W'(WAYS - 1))   victim_way = WAY_W'(w);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int g = 0; g < GROUPS; g++)
                    for (int w = 0; w < WAYS; w++)
                        age_q[g][w] <= WAY_W'(w);
            end else if (touch) begin
                age_q[grp] <= row_d;
            end
        end
    end else begin : g_rand
        logic [7:0] lfsr_q, lfsr_d;
        logic       unused_rand;

        assign unused_rand = ^{grp, touch, touch_way};
        assign lfsr_d      = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
        assign victim_way  = lfsr_q[WAY_W-1:0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lfsr_q <= 8'h01;
            else        lfsr_q <= lfsr_d;
        end
    end
endmodule

// File: rtl/bcache_top.sv
module bcache_top #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int NPI_W  = 6,
    parameter int PI_W   = 6,
    parameter int OI_W   = 9,
    parameter int WORD_W = 32,
    parameter bcache_pkg::repl_e REPL = bcache_pkg::REPL_LRU,
    localparam int LINE_W = 8 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_hit,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    import bcache_pkg::*;

    localparam int WAY_W      = OI_W - NPI_W;
    localparam int WAYS       = 1 << WAY_W;
    localparam int GROUPS     = 1 << NPI_W;
    localparam int LINES      = GROUPS * WAYS;
    localparam int IDX_W      = NPI_W + WAY_W;
    localparam int TAG_W      = ADDR_W - OFF_W - NPI_W - PI_W;
    localparam int WORDS      = LINE_W / WORD_W;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int BYTE_W     = OFF_W - WSEL_W;
    localparam int GRP_LSB    = OFF_W;
    localparam int PI_LSB     = OFF_W + NPI_W;
    localparam int TAG_LSB    = OFF_W + NPI_W + PI_W;

    typedef struct packed {
        st_e               st;
        logic              hit;
        logic [WORD_W-1:0] rdata;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [WORD_W-1:0] wdata;
        logic [WAY_W-1:0]  way;
        logic              mreq;
        logic              mwe;
        logic [ADDR_W-1:0] maddr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    // line storage: decoder entries, tags, state bits, data
    logic [LINES-1:0]  valid_q, dirty_q;
    logic [PI_W-1:0]   pd_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    // lookup address: live request while idle, captured request during a miss
    logic [ADDR_W-1:0] lk_addr;
    logic [NPI_W-1:0]  lk_grp;
    logic [PI_W-1:0]   lk_pi;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_word;
    logic              unused_bits;

    assign lk_addr     = (ctl_q.st == ST_IDLE) ? cpu_addr : ctl_q.addr;
    assign lk_grp      = lk_addr[GRP_LSB +: NPI_W];
    assign lk_pi       = lk_addr[PI_LSB +: PI_W];
    assign lk_tag      = lk_addr[TAG_LSB +: TAG_W];
    assign lk_word     = lk_addr[BYTE_W +: WSEL_W];
    assign unused_bits = ^{lk_addr[BYTE_W-1:0], ctl_q.addr[BYTE_W-1:0]};

    logic [WAYS-1:0]            grp_valid;
    logic [WAYS-1:0][PI_W-1:0]  grp_pd;
    logic [WAYS-1:0][TAG_W-1:0] grp_tag;

    for (genvar w = 0; w < WAYS; w++) begin : g_grp
        assign grp_valid[w] = valid_q[{lk_grp, WAY_W'(w)}];
        assign grp_pd[w]    = pd_q[{lk_grp, WAY_W'(w)}];
        assign grp_tag[w]   = tag_q[{lk_grp, WAY_W'(w)}];
    end

    logic [WAYS-1:0]  pd_match;
    logic             match_any, tag_hit, free_any;
    logic [WAY_W-1:0] match_way, free_way, repl_way, vic_way;

    bcache_decoder #(.WAYS(WAYS), .WAY_W(WAY_W), .PI_W(PI_W), .TAG_W(TAG_W)) u_dec (
        .ent_valid (grp_valid),
        .ent_pd    (grp_pd),
        .ent_tag   (grp_tag),
        .req_pd    (lk_pi),
        .req_tag   (lk_tag),
        .pd_match  (pd_match),
        .match_any (match_any),
        .match_way (match_way),
        .tag_hit   (tag_hit),
        .free_any  (free_any),
        .free_way  (free_way)
    );

    logic             touch;
    logic [WAY_W-1:0] touch_way;

    bcache_repl #(.REPL(REPL), .NPI_W(NPI_W), .WAY_W(WAY_W)) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp        (lk_grp),
        .touch      (touch),
        .touch_way  (touch_way),
        .victim_way (repl_way)
    );

    // same programmable value must reuse its line; then empty; then policy
    assign vic_way = match_any ? match_way : (free_any ? free_way : repl_way);

    function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] line,
                                                     input logic [WSEL_W-1:0] sel,
                                                     input logic [WORD_W-1:0] word);
        logic [LINE_W-1:0] res;
        res = line;
        for (int i = 0; i < WORDS; i++)
            if (i == int'(sel)) res[i*WORD_W +: WORD_W] = word;
        return res;
    endfunction

    logic [IDX_W-1:0]  hit_idx, vic_idx, cap_idx, wr_idx;
    logic [LINE_W-1:0] wr_line;
    logic              line_we, ent_we, dirty_we, dirty_val;

    assign hit_idx = {lk_grp, match_way};
    assign vic_idx = {lk_grp, vic_way};
    assign cap_idx = {lk_grp, ctl_q.way};

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.hit = 1'b0;
        line_we   = 1'b0;
        ent_we    = 1'b0;
        dirty_we  = 1'b0;
        dirty_val = 1'b0;
        touch     = 1'b0;
        touch_way = match_way;
        wr_idx    = hit_idx;
        wr_line   = merge_word(data_q[hit_idx], lk_word, cpu_wdata);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.addr  = cpu_addr;
                    ctl_d.we    = cpu_we;
                    ctl_d.wdata = cpu_wdata;
                    if (tag_hit) begin
                        ctl_d.hit   = 1'b1;
                        touch       = 1'b1;
                        ctl_d.rdata = data_q[hit_idx][lk_word*WORD_W +: WORD_W];
                        if (cpu_we) begin
                            line_we     = 1'b1;
                            dirty_we    = 1'b1;
                            dirty_val   = 1'b1;
                            ctl_d.rdata = cpu_wdata;
                        end
                    end else begin
                        ctl_d.way  = vic_way;
                        ctl_d.mreq = 1'b1;
                        if (valid_q[vic_idx] && dirty_q[vic_idx]) begin
                            ctl_d.st    = ST_WB;
                            ctl_d.mwe   = 1'b1;
                            ctl_d.maddr = {tag_q[vic_idx], pd_q[vic_idx], lk_grp, OFF_W'(0)};
                        end else begin
                            ctl_d.st    = ST_RF;
                            ctl_d.mwe   = 1'b0;
                            ctl_d.maddr = {cpu_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                        end
                    end
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    ctl_d.st    = ST_RF;
                    ctl_d.mwe   = 1'b0;
                    ctl_d.maddr = {ctl_q.addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                end
            end
            ST_RF: begin
                wr_idx  = cap_idx;
                wr_line = ctl_q.we ? merge_word(mem_rdata, lk_word, ctl_q.wdata) : mem_rdata;
                if (mem_ack) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.mreq  = 1'b0;
                    ctl_d.hit   = 1'b1;
                    ctl_d.rdata = wr_line[lk_word*WORD_W +: WORD_W];
                    line_we     = 1'b1;
                    ent_we      = 1'b1;
                    dirty_we    = 1'b1;
                    dirty_val   = ctl_q.we;
                    touch       = 1'b1;
                    touch_way   = ctl_q.way;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (ent_we)   valid_q[wr_idx] <= 1'b1;
            if (dirty_we) dirty_q[wr_idx] <= dirty_val;
        end
    end

    always_ff @(posedge clk) begin
        if (line_we) data_q[wr_idx] <= wr_line;
        if (ent_we) begin
            pd_q[wr_idx]  <= lk_pi;
            tag_q[wr_idx] <= lk_tag;
        end
    end

    assign cpu_hit   = ctl_q.hit;
    assign cpu_rdata = ctl_q.rdata;
    assign mem_req   = ctl_q.mreq;
    assign mem_we    = ctl_q.mwe;
    assign mem_addr  = ctl_q.maddr;
    assign mem_wdata = data_q[cap_idx];
endmodule

// File: rtl/bcache_checker.sv
module bcache_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int WAYS   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_hit,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WAYS-1:0]   pd_match
);
    assert_hit_no_traffic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> !mem_req);

    assert_line_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    assert_wb_then_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    assert_unique_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pd_match));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!cpu_hit && !mem_req);
        end
    end
endmodule

bind bcache_top bcache_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_hit  (cpu_hit),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .pd_match (pd_match)
);

// File: tb/bcache_top_test.sv
module bcache_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]       cpu_addr = '0, cpu_wdata = '0;
    logic              cpu_hit;
    logic [31:0]       cpu_rdata;
    logic              mem_req, mem_we;
    logic [31:0]       mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcache_top #(.REPL(bcache_pkg::REPL_LRU)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // next-level memory and architectural shadow, both word-addressed
    logic [31:0] mem_m  [int unsigned];
    logic [31:0] shadow [int unsigned];

    function automatic logic [31:0] initv(input int unsigned wa);
        return (wa * 32'h9E37_79B1) ^ 32'h3C3C_A5A5;
    endfunction
    function automatic logic [31:0] rd_mem(input int unsigned wa);
        return mem_m.exists(wa) ? mem_m[wa] : initv(wa);
    endfunction
    function automatic logic [31:0] rd_shadow(input int unsigned wa);
        return shadow.exists(wa) ? shadow[wa] : initv(wa);
    endfunction
    function automatic logic [31:0] mk(input int g, input int pd, input int tg, input int wd);
        return (32'(tg) << 17) | (32'(pd) << 11) | (32'(g) << 5) | (32'(wd) << 2);
    endfunction

    int          wb_cnt = 0, rf_cnt = 0;
    logic [31:0] wb_addr = '0, rf_addr = '0;
    logic [LINE_W-1:0] wb_data = '0;

    // memory responder: acknowledges after two idle cycles, checks hold (R11)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && !mem_ack) begin
                logic [31:0] a;
                logic        w;
                a = mem_addr;
                w = mem_we;
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    chk(mem_req === 1'b1 && mem_addr === a && mem_we === w, "R11",
                        "request held stable", {mem_req, mem_we, mem_addr}, {1'b1, w, a});
                end
                if (w) begin
                    for (int i = 0; i < 8; i++) mem_m[(a >> 2) + i] = mem_wdata[i*32 +: 32];
                    wb_cnt++;
                    wb_addr = a;
                    wb_data = mem_wdata;
                end else begin
                    for (int i = 0; i < 8; i++) mem_rdata[i*32 +: 32] = rd_mem((a >> 2) + i);
                    rf_cnt++;
                    rf_addr = a;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // block-level LRU model: index 0 most recent
    int   m_cnt [64];
    int   m_pd  [64][8];
    int   m_tag [64][8];
    bit   m_dty [64][8];

    task automatic model(input int g, input int pd, input int tg, input bit we,
                         output bit hit, output bit wb, output logic [31:0] wba);
        int pos;
        int vpd, vtg;
        bit vd;
        pos = -1;
        hit = 0; wb = 0; wba = '0;
        for (int i = 0; i < m_cnt[g]; i++) if (m_pd[g][i] == pd) pos = i;
        if (pos >= 0 && m_tag[g][pos] == tg) begin
            hit = 1;
            vd  = m_dty[g][pos] | we;
        end else begin
            if (pos < 0) begin
                if (m_cnt[g] < 8) begin
                    pos = m_cnt[g];
                    m_cnt[g]++;
                    m_pd[g][pos] = -1;
                    m_dty[g][pos] = 0;
                end else pos = 7;
            end
            if (m_pd[g][pos] >= 0 && m_dty[g][pos]) begin
                wb  = 1;
                wba = mk(g, m_pd[g][pos], m_tag[g][pos], 0);
            end
            vd = we;
        end
        for (int i = pos; i > 0; i--) begin
            m_pd[g][i]  = m_pd[g][i-1];
            m_tag[g][i] = m_tag[g][i-1];
            m_dty[g][i] = m_dty[g][i-1];
        end
        m_pd[g][0] = pd; m_tag[g][0] = tg; m_dty[g][0] = vd;
    endtask

    task automatic access(input logic [31:0] addr, input bit we, input logic [31:0] wd,
                          output bit was_hit);
        int g, pd, tg, n, wb0, rf0;
        bit ehit, ewb;
        logic [31:0] ewba;
        int unsigned wa;
        g  = int'(addr[10:5]);
        pd = int'(addr[16:11]);
        tg = int'(addr[31:17]);
        wa = addr >> 2;
        model(g, pd, tg, we, ehit, ewb, ewba);
        wb0 = wb_cnt; rf0 = rf_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!cpu_hit && n < 200);
        cpu_req = 1'b0;
        was_hit = (n == 1);
        chk(n < 200, "R3", "access completes", 64'(n), 64'(199));
        if (ehit)
            chk(n == 1 && rf_cnt == rf0, "R2", "hit in one cycle", 64'(n), 64'(1));
        else begin
            chk(n > 1 && rf_cnt == rf0 + 1, "R3", "miss refills once", 64'(rf_cnt - rf0), 64'(1));
            chk(rf_addr == {addr[31:5], 5'd0}, "R3", "refill address", 64'(rf_addr),
                64'({addr[31:5], 5'd0}));
        end
        chk(wb_cnt - wb0 == int'(ewb), "R5", "write-back count", 64'(wb_cnt - wb0), 64'(ewb));
        if (ewb && wb_cnt - wb0 == 1) begin
            chk(wb_addr == ewba, "R1", "write-back address", 64'(wb_addr), 64'(ewba));
            for (int i = 0; i < 8; i++)
                chk(wb_data[i*32 +: 32] == rd_shadow((ewba >> 2) + i), "R5", "write-back data",
                    64'(wb_data[i*32 +: 32]), 64'(rd_shadow((ewba >> 2) + i)));
        end
        if (we) shadow[wa] = wd;
        else chk(cpu_rdata == rd_shadow(wa), "R4", "read data", 64'(cpu_rdata), 64'(rd_shadow(wa)));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit h;
        int wb0;
        void'($urandom(32'd20240611));
        for (int g = 0; g < 64; g++) m_cnt[g] = 0;
        repeat (3) @(negedge clk);
        chk(cpu_hit == 1'b0 && mem_req == 1'b0, "R10", "outputs in reset", {cpu_hit, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_hit == 1'b0 && mem_req == 1'b0, "R10", "outputs after reset", {cpu_hit, mem_req}, 0);

        // first access after reset misses (R10)
        access(mk(2, 0, 0, 1), 0, '0, h);
        chk(!h, "R10", "first access misses", 64'(h), 0);

        // R8 / R6: eight programmable values fill group 5, all dirty, no eviction
        wb0 = wb_cnt;
        for (int p = 0; p < 8; p++) access(mk(5, p, 0, p), 1, 32'hA000_0000 + p, h);
        chk(wb_cnt == wb0, "R8", "no eviction while lines free", 64'(wb_cnt - wb0), 0);
        for (int p = 0; p < 8; p++) begin
            access(mk(5, p, 0, p), 0, '0, h);
            chk(h, "R6", "co-resident line hits", 64'(h), 1);
        end

        // R9: touch value 0, then a ninth value must evict value 1
        access(mk(5, 0, 0, 3), 0, '0, h);
        wb0 = wb_cnt;
        access(mk(5, 8, 0, 0), 0, '0, h);
        chk(wb_cnt == wb0 + 1 && wb_addr == mk(5, 1, 0, 0), "R9", "LRU victim",
            64'(wb_addr), 64'(mk(5, 1, 0, 0)));
        access(mk(5, 0, 0, 0), 0, '0, h);
        chk(h, "R9", "recently touched line kept", 64'(h), 1);

        // R7: same programmable value, other tag, replaces that line only
        access(mk(9, 4, 0, 0), 0, '0, h);
        access(mk(9, 3, 0, 2), 1, 32'h1234_5678, h);
        wb0 = wb_cnt;
        access(mk(9, 3, 1, 2), 0, '0, h);
        chk(!h && wb_cnt == wb0 + 1 && wb_addr == mk(9, 3, 0, 0), "R7", "matching line replaced",
            64'(wb_addr), 64'(mk(9, 3, 0, 0)));
        access(mk(9, 4, 0, 5), 0, '0, h);
        chk(h, "R7", "other line kept", 64'(h), 1);
        access(mk(9, 3, 0, 2), 0, '0, h);
        chk(!h, "R7", "old block no longer matches", 64'(h), 0);

        // R4: write hit then read back
        access(mk(9, 4, 0, 6), 1, 32'hCAFE_F00D, h);
        access(mk(9, 4, 0, 6), 0, '0, h);
        chk(h && cpu_rdata == 32'hCAFE_F00D, "R4", "write hit read back", 64'(cpu_rdata),
            64'(32'hCAFE_F00D));

        // random traffic over three groups, twelve values, two tags
        for (int k = 0; k < 1500; k++) begin
            int gsel, g, p, t, wd;
            bit we;
            gsel = int'($urandom_range(2, 0));
            g  = (gsel == 0) ? 0 : (gsel == 1) ? 1 : 63;
            p  = int'($urandom_range(11, 0));
            t  = int'($urandom_range(1, 0));
            wd = int'($urandom_range(7, 0));
            we = ($urandom_range(9, 0) < 3);
            access(mk(g, p, t, wd), we, $urandom, h);
        end

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule